// File: doc/BRIEF.md
# Key-Gated Register Write Protection

This block guards the configuration registers of a serial peripheral against stray software writes. It sits on a simple register write bus (word offset, data, write strobe) between the bus decoder and the peripheral's register file. Every write to an unprotected offset goes straight through to the register file. A write to a protected offset goes through only while protection is off.

The guard owns its own protection mode register. That register accepts a write only when the upper bits of the write data carry a fixed access key. A keyed write loads the enable bit and clears the violation flag. While protection is on, a blocked write raises a sticky violation flag and records the word offset it was aimed at. A mode write with a wrong key is also blocked and recorded. The flag, the recorded offset and the enable bit are plain outputs, so reading them has no side effects.

Top module: `wp_guard`

## Requirements
- R1: After reset, `prot_en_o` is 0, `viol_o` is 0 and `viol_src_o` is 0.
- R2: A write to an offset outside the protected set always asserts `regf_we` in the same cycle, with `regf_addr`/`regf_data` equal to `wr_addr`/`wr_data`, whatever the enable bit is.
- R3: The protected set is offsets 0x01, 0x04, 0x05, 0x06, 0x07, 0x0C, 0x0D and the mode register at 0x39. While `prot_en_o` is 0, writes to 0x01, 0x04–0x07, 0x0C and 0x0D pass. While it is 1, they are blocked and `regf_we` stays 0.
- R4: A blocked write sets `viol_o` from the next cycle on. The flag stays set until a keyed mode write clears it.
- R5: On each blocked write, `viol_src_o` takes the target offset from the next cycle on, so it always holds the most recent violation.
- R6: A write to 0x39 whose data bits [31:8] equal the key 0xA5C33C loads `prot_en_o` from data bit 0 and clears `viol_o` from the next cycle. `viol_src_o` is left unchanged.
- R7: A write to 0x39 with a wrong key changes neither `prot_en_o` nor a cleared flag. While protection is on, it counts as a violation with source 0x39. While protection is off, it has no effect at all.
- R8: A write to 0x39 never asserts `regf_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe from the bus |
| wr_addr | input | 8 | Word offset of the write |
| wr_data | input | 32 | Write data |
| regf_we | output | 1 | Gated write strobe to the register file |
| regf_addr | output | 8 | Offset forwarded to the register file |
| regf_data | output | 32 | Data forwarded to the register file |
| prot_en_o | output | 1 | Protection enable state |
| viol_o | output | 1 | Sticky violation flag |
| viol_src_o | output | 8 | Offset of the most recent blocked write |

## Verification
Suppose the enable bit is wrong or the address match misses an entry. Then `regf_we` takes the wrong value in the very cycle of the write, and the next cycle `viol_o` either stays clear or rises when it should not. A wrong source capture or a missing clear shows on `viol_src_o` and `viol_o` one cycle after the write. The bench sweeps every offset in both protection states, so any entry missing from the protected set shows up as a strobe mismatch at that offset.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;
   // Classification of the write presented in the current cycle
   typedef enum logic [1:0] {
      WP_IDLE  = 2'd0,
      WP_PASS  = 2'd1,
      WP_BLOCK = 2'd2,
      WP_MODE  = 2'd3
   } wp_act_e;
endpackage

// File: rtl/wp_addr_match.sv
module wp_addr_match #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned NPROT  = 8,
   parameter logic [NPROT*ADDR_W-1:0] PROT_LIST = '0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   logic [NPROT-1:0] hit_vec;

   generate
      for (genvar i = 0; i < NPROT; i++) begin : g_cmp
         assign hit_vec[i] = (addr == PROT_LIST[i*ADDR_W +: ADDR_W]);
      end
   endgenerate

   assign hit = |hit_vec;
endmodule

// File: rtl/wp_mode_reg.sv
module wp_mode_reg #(
   parameter int unsigned KEY_W = 24,
   parameter logic [KEY_W-1:0] KEY = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_wr,
   input  logic [KEY_W-1:0] key_in,
   input  logic             en_in,
   output logic             prot_en,
   output logic             key_ok,
   output logic             keyed_wr
);
   assign key_ok   = (key_in == KEY);
   assign keyed_wr = mode_wr & key_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        prot_en <= 1'b0;
      else if (keyed_wr) prot_en <= en_in;
   end

   AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !keyed_wr |=> $stable(prot_en)); // R7
   AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      keyed_wr |=> (prot_en == $past(en_in))); // R6
endmodule

// File: rtl/wp_status_reg.sv
module wp_status_reg #(
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              viol_set,
   input  logic [ADDR_W-1:0] viol_addr,
   input  logic              viol_clr,
   output logic              flag,
   output logic [ADDR_W-1:0] src
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
         src  <= '0;
      end else if (viol_set) begin
         flag <= 1'b1;
         src  <= viol_addr;
      end else if (viol_clr) begin
         flag <= 1'b0;
      end
   end

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !viol_clr) |=> flag); // R4
   AST_SRC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      viol_set |=> (flag && src == $past(viol_addr))); // R5
   AST_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(viol_set && viol_clr)); // R6
endmodule

// File: rtl/wp_guard.sv
module wp_guard #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned KEY_W     = 24,
   parameter logic [KEY_W-1:0] KEY  = 24'hA5C33C,
   parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h39,
   parameter int unsigned NPROT     = 8,
   parameter logic [NPROT*ADDR_W-1:0] PROT_LIST =
      {8'h39, 8'h0D, 8'h0C, 8'h07, 8'h06, 8'h05, 8'h04, 8'h01}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              regf_we,
   output logic [ADDR_W-1:0] regf_addr,
   output logic [DATA_W-1:0] regf_data,
   output logic              prot_en_o,
   output logic              viol_o,
   output logic [ADDR_W-1:0] viol_src_o
);
   import wp_guard_pkg::*;

   localparam int unsigned KEY_LSB = DATA_W - KEY_W;

   generate
      if (DATA_W < KEY_W + 1) begin : g_bad_width
         $error("wp_guard: DATA_W must hold the key and the enable bit");
      end
      if (NPROT < 1) begin : g_bad_nprot
         $error("wp_guard: NPROT must be at least 1");
      end
   endgenerate

   logic    prot_hit, is_mode, key_ok, keyed_wr, viol_set;
   wp_act_e act;

   wp_addr_match #(.ADDR_W(ADDR_W), .NPROT(NPROT), .PROT_LIST(PROT_LIST)) u_match (
      .addr (wr_addr),
      .hit  (prot_hit)
   );

   assign is_mode = (wr_addr == MODE_ADDR);

   always_comb begin
      if (!wr_en)                      act = WP_IDLE;
      else if (is_mode)                act = WP_MODE;
      else if (prot_en_o && prot_hit)  act = WP_BLOCK;
      else                             act = WP_PASS;
   end

   wp_mode_reg #(.KEY_W(KEY_W), .KEY(KEY)) u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_wr  (act == WP_MODE),
      .key_in   (wr_data[DATA_W-1:KEY_LSB]),
      .en_in    (wr_data[0]),
      .prot_en  (prot_en_o),
      .key_ok   (key_ok),
      .keyed_wr (keyed_wr)
   );

   assign viol_set = (act == WP_BLOCK) || ((act == WP_MODE) && prot_en_o && !key_ok);

   wp_status_reg #(.ADDR_W(ADDR_W)) u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .viol_set  (viol_set),
      .viol_addr (wr_addr),
      .viol_clr  (keyed_wr),
      .flag      (viol_o),
      .src       (viol_src_o)
   );

   assign regf_we   = (act == WP_PASS);
   assign regf_addr = wr_addr;
   assign regf_data = wr_data;

   AST_UNPROT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !prot_hit) |-> regf_we); // R2
   AST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && prot_en_o && prot_hit) |-> !regf_we); // R3
   AST_MODE_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && is_mode) |-> !regf_we); // R8
   AST_VIOL_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && prot_en_o && prot_hit && !keyed_wr) |=> viol_o); // R4
endmodule

// File: tb/wp_guard_test.sv
module wp_guard_test;
   localparam logic [23:0] KEY  = 24'hA5C33C;
   localparam logic [7:0]  MODE = 8'h39;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        regf_we;
   logic [7:0]  regf_addr;
   logic [31:0] regf_data;
   logic        prot_en_o, viol_o;
   logic [7:0]  viol_src_o;

   int n_run = 0;
   int n_fail = 0;
   logic we_seen;

   always #2.5 clk = ~clk;

   wp_guard uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .regf_we(regf_we), .regf_addr(regf_addr), .regf_data(regf_data),
      .prot_en_o(prot_en_o), .viol_o(viol_o), .viol_src_o(viol_src_o)
   );

   function automatic bit is_prot(input logic [7:0] a);
      return a == 8'h01 || (a >= 8'h04 && a <= 8'h07) || a == 8'h0C || a == 8'h0D || a == MODE;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Drive one write; records the strobe mid-cycle, returns after the edge.
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      #1;
      we_seen = regf_we;
      if (regf_we) begin
         chk("R2 addr fwd", {24'h0, regf_addr}, {24'h0, a});
         chk("R2 data fwd", regf_data, d);
      end
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   initial begin
      #100000;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] last_src;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1 prot_en", {31'h0, prot_en_o}, 0);
      chk("R1 viol", {31'h0, viol_o}, 0);
      chk("R1 src", {24'h0, viol_src_o}, 0);
      rst_n = 1'b1;

      // Protection off: everything but the mode register passes (R2, R3, R8)
      for (int a = 0; a < 256; a++) begin
         wr(a[7:0], {a[7:0], 24'h5A0000} ^ 32'h13);
         chk(a == MODE ? "R8 mode not fwd" : "R3 pass when off",
             {31'h0, we_seen}, {31'h0, a[7:0] != MODE});
      end
      chk("R7 wrong key when off", {31'h0, viol_o}, 0);
      chk("R7 enable untouched", {31'h0, prot_en_o}, 0);

      // Wrong key does not enable (R7)
      wr(MODE, {24'hA5C33D, 8'h01});
      chk("R7 bad key no enable", {31'h0, prot_en_o}, 0);
      chk("R7 bad key no flag", {31'h0, viol_o}, 0);

      // Keyed enable (R6)
      wr(MODE, {KEY, 8'h01});
      chk("R6 keyed enable", {31'h0, prot_en_o}, 1);
      chk("R8 keyed mode not fwd", {31'h0, we_seen}, 0);

      // Protection on: sweep (R2, R3, R4, R5)
      last_src = 8'h00;
      for (int a = 0; a < 256; a++) begin
         if (a[7:0] == MODE) continue;
         wr(a[7:0], 32'hCAFE0000 | a);
         if (is_prot(a[7:0])) last_src = a[7:0];
         chk(is_prot(a[7:0]) ? "R3 blocked when on" : "R2 unprotected pass",
             {31'h0, we_seen}, {31'h0, !is_prot(a[7:0])});
         chk("R4 sticky flag", {31'h0, viol_o}, {31'h0, last_src != 0});
         chk("R5 latest src", {24'h0, viol_src_o}, {24'h0, last_src});
      end

      // Wrong key while on: violation at mode offset, enable kept (R7)
      wr(MODE, {24'h000000, 8'h00});
      chk("R7 bad key src", {24'h0, viol_src_o}, {24'h0, MODE});
      chk("R7 bad key keeps enable", {31'h0, prot_en_o}, 1);
      chk("R7 flag held", {31'h0, viol_o}, 1);

      // Keyed clear keeping protection on (R6)
      wr(MODE, {KEY, 8'h01});
      chk("R6 flag cleared", {31'h0, viol_o}, 0);
      chk("R6 src retained", {24'h0, viol_src_o}, {24'h0, MODE});
      chk("R6 enable kept", {31'h0, prot_en_o}, 1);

      // Fresh violation then keyed disable clears and reopens (R4, R5, R6, R3)
      wr(8'h0C, 32'h1);
      chk("R4 flag re-raised", {31'h0, viol_o}, 1);
      chk("R5 src 0x0C", {24'h0, viol_src_o}, 32'h0C);
      wr(MODE, {KEY, 8'h00});
      chk("R6 disable", {31'h0, prot_en_o}, 0);
      chk("R6 clear on disable", {31'h0, viol_o}, 0);
      wr(8'h06, 32'h77);
      chk("R3 pass after disable", {31'h0, we_seen}, 1);
      chk("R4 no flag after disable", {31'h0, viol_o}, 0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule